// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects level-style requests from a set of on-chip sources plus one active-low external pin. It gives each source a programmable priority and picks one winner, whose vector number and priority level go to a processor core. Each source has a 2-bit priority code. One code value turns the source off, and the other three select priority levels 0, 1 and 2. Two fast slots let software name vector numbers that win over ordinary sources of the same level. Fast slot 0 beats fast slot 1.

The core supplies its current mask level and an acknowledge strobe. Only requests at or above the mask level are forwarded, so the core can nest exceptions by raising the mask to one above the level it is serving. Once a request is presented, it is held until the core acknowledges it or the source withdraws it.

The external pin is sensitive to a low level by default. A control bit can make it sensitive to a falling edge instead. A low-power flag (stop or wait) forces level sensitivity, whatever the control bit holds. Software reaches priority codes, fast slots, the pin mode, pending bits and a sending-status bit through a simple register port with a combinational read. Source i has vector number VEC_BASE+i (default VEC_BASE=2). Source 0 is the external pin, and peripheral line k is source k+1.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all priority codes, both fast slots and the control register read 0, and irq_req_o is 0.
- R2: Priority code 2'b00 disables a source, so it is neither pending nor presented. Codes 01, 10 and 11 give levels 0, 1 and 2 on irq_lvl_o, which never shows 3. The code of source i sits at bits [2*(i%8)+1:2*(i%8)] of the register at address 4+i/8.
- R3: The pending bit of source i (enabled and requesting) reads at bit i%16 of the register at address 4+ceil(NUM_SRC/8)+i/16. That is address 6 with 16 sources. Bits with no source read 0, and writes to that address have no effect.
- R4: The highest level wins. Among ordinary sources at equal level, the lowest vector number wins.
- R5: A source whose vector equals fast slot 0 (address 1, bits 6:0) or fast slot 1 (address 2) wins over ordinary sources at its own level, and slot 0 wins over slot 1. A higher-level ordinary source still wins.
- R6: A request is forwarded only when its level is at least core_mask_i. If the mask rises above the level being presented, irq_req_o drops on the next cycle.
- R7: While irq_req_o is high, vector and level hold until irq_ack_i or withdrawal of the presented source. On acknowledge, the next choice is made in the same cycle with the acknowledged source left out, and it appears one cycle later.
- R8: Bit 15 of the control register (address 0) reads 1 exactly when irq_req_o is 1, and writing it has no effect.
- R9: With control bit 0 clear, the external pin (source 0) requests while it is held low, after a two-flop synchronizer.
- R10: With control bit 0 set, a falling edge on the pin latches a request. The request stays after the pin returns high and is cleared when the core acknowledges source 0.
- R11: While lowpwr_i is high, the pin acts in level mode whatever bit 0 holds: no edge is latched, and a held-low pin requests. Bit 0 keeps its value.
- R12: Outputs are registered, so a change on a peripheral line shows on the outputs after one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_req_i | input | NUM_SRC-1 | Peripheral request lines, active high; line k is source k+1 |
| ext_irq_ni | input | 1 | External interrupt pin, active low |
| lowpwr_i | input | 1 | Stop/wait indication, forces level sensitivity |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational |
| core_mask_i | input | 2 | Lowest level the core accepts |
| irq_ack_i | input | 1 | Core acknowledge of the presented request |
| irq_req_o | output | 1 | Request to the core |
| irq_lvl_o | output | 2 | Level of the presented request |
| irq_vec_o | output | 7 | Vector number of the presented request |

## Verification
Arbitration is driven with simultaneous requests that differ only in level, only in vector number, and only in fast-slot membership. Each pattern separates one ranking rule from the others, including slot 0 against slot 1 and a fast slot against a higher ordinary level. Mask sweeps and a higher request arriving under a held one separate forwarding from preemption. An acknowledge then shows that the new choice follows at once. The external pin is pulsed and held low in level mode, edge mode and low-power mode. A short pulse tells the three modes apart, since only edge mode keeps it after the pin is released.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int VEC_W = 7;
  localparam int LVL_W = 2;
  localparam int REG_W = 16;

  localparam int ADR_CTL       = 0;
  localparam int ADR_FAST0     = 1;
  localparam int ADR_FAST1     = 2;
  localparam int ADR_PRIO_BASE = 4;

  localparam int CODES_PER_REG = REG_W / 2;

  typedef logic [1:0] prio_code_t;
  localparam prio_code_t PRIO_OFF = 2'b00;

  function automatic logic [LVL_W-1:0] code_to_lvl(input prio_code_t c);
    return c - 2'd1;
  endfunction
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  output logic [REG_W-1:0]              rdata_o,
  input  logic [NUM_SRC-1:0]            pend_i,
  input  logic                          sending_i,
  output logic [NUM_SRC-1:0][1:0]       prio_o,
  output logic [VEC_W-1:0]              fast0_o,
  output logic [VEC_W-1:0]              fast1_o,
  output logic                          edge_sel_o
);
  localparam int NPRIO     = (NUM_SRC + CODES_PER_REG - 1) / CODES_PER_REG;
  localparam int NPEND     = (NUM_SRC + REG_W - 1) / REG_W;
  localparam int PEND_BASE = ADR_PRIO_BASE + NPRIO;

  logic [NPRIO-1:0][REG_W-1:0] prio_q, prio_d;
  logic [VEC_W-1:0]            fast0_q, fast0_d, fast1_q, fast1_d;
  logic                        edge_q, edge_d;
  logic [NPEND*REG_W-1:0]      pend_pad;

  assign pend_pad = {{(NPEND*REG_W-NUM_SRC){1'b0}}, pend_i};

  // next state
  always_comb begin
    prio_d  = prio_q;
    fast0_d = fast0_q;
    fast1_d = fast1_q;
    edge_d  = edge_q;
    if (wr_en_i) begin
      if (addr_i == ADDR_W'(ADR_CTL))   edge_d  = wdata_i[0];
      if (addr_i == ADDR_W'(ADR_FAST0)) fast0_d = wdata_i[VEC_W-1:0];
      if (addr_i == ADDR_W'(ADR_FAST1)) fast1_d = wdata_i[VEC_W-1:0];
      for (int r = 0; r < NPRIO; r++) begin
        if (addr_i == ADDR_W'(ADR_PRIO_BASE + r)) prio_d[r] = wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q  <= '0;
      fast0_q <= '0;
      fast1_q <= '0;
      edge_q  <= 1'b0;
    end else if (wr_en_i) begin
      prio_q  <= prio_d;
      fast0_q <= fast0_d;
      fast1_q <= fast1_d;
      edge_q  <= edge_d;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADR_CTL))   rdata_o = {sending_i, {(REG_W-2){1'b0}}, edge_q};
    if (addr_i == ADDR_W'(ADR_FAST0)) rdata_o = {{(REG_W-VEC_W){1'b0}}, fast0_q};
    if (addr_i == ADDR_W'(ADR_FAST1)) rdata_o = {{(REG_W-VEC_W){1'b0}}, fast1_q};
    for (int r = 0; r < NPRIO; r++) begin
      if (addr_i == ADDR_W'(ADR_PRIO_BASE + r)) rdata_o = prio_q[r];
    end
    for (int p = 0; p < NPEND; p++) begin
      if (addr_i == ADDR_W'(PEND_BASE + p)) rdata_o = pend_pad[p*REG_W +: REG_W];
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_code
    assign prio_o[i] = prio_q[i / CODES_PER_REG][2*(i % CODES_PER_REG) +: 2];
  end

  assign fast0_o    = fast0_q;
  assign fast1_o    = fast1_q;
  assign edge_sel_o = edge_q;

  // R8
  sending_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(ADR_CTL)) |=> (rdata_o[REG_W-1] == sending_i || addr_i != ADDR_W'(ADR_CTL)));
endmodule

// File: rtl/prio_irq_ext_pin.sv
module prio_irq_ext_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic edge_sel_i,
  input  logic lowpwr_i,
  input  logic ack_i,
  output logic req_o
);
  logic s1_q, s2_q, prev_q, latch_q;
  logic latch_d, edge_mode, fall;

  assign edge_mode = edge_sel_i && !lowpwr_i;
  assign fall      = prev_q && !s2_q;

  always_comb begin
    latch_d = latch_q;
    if (!edge_mode)  latch_d = 1'b0;
    else if (fall)   latch_d = 1'b1;
    else if (ack_i)  latch_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      s1_q    <= pin_ni;
      s2_q    <= s1_q;
      prev_q  <= s2_q;
      latch_q <= latch_d;
    end
  end

  assign req_o = edge_mode ? latch_q : !s2_q;

  // R11
  lowpwr_no_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowpwr_i |=> !latch_q);

  // R10
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && latch_q && !ack_i) |=> (latch_q || !edge_mode));
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int VEC_BASE = 2,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       pend_i,
  input  logic [NUM_SRC-1:0]       excl_i,
  input  logic [NUM_SRC-1:0][1:0]  prio_i,
  input  logic [VEC_W-1:0]         fast0_i,
  input  logic [VEC_W-1:0]         fast1_i,
  input  logic [LVL_W-1:0]         mask_i,
  output logic                     win_valid_o,
  output logic [IDX_W-1:0]         win_idx_o,
  output logic [LVL_W-1:0]         win_lvl_o,
  output logic [VEC_W-1:0]         win_vec_o
);
  logic [NUM_SRC-1:0][VEC_W-1:0] vec;
  logic [NUM_SRC-1:0][3:0]       score;
  logic [NUM_SRC-1:0]            elig;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign vec[i]   = VEC_W'(VEC_BASE + i);
    assign elig[i]  = pend_i[i] && !excl_i[i] && (code_to_lvl(prio_i[i]) >= mask_i);
    assign score[i] = {code_to_lvl(prio_i[i]), vec[i] == fast0_i, vec[i] == fast1_i};
  end

  // scan from lowest index; strict compare keeps the lowest vector on ties
  always_comb begin
    logic [3:0] best;
    best        = '0;
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!win_valid_o || score[i] > best)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        best        = score[i];
      end
    end
    win_lvl_o = best[3:2];
    win_vec_o = vec[win_idx_o];
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int VEC_BASE = 2,
  parameter int ADDR_W   = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-2:0]   src_req_i,
  input  logic                 ext_irq_ni,
  input  logic                 lowpwr_i,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [15:0]          reg_wdata_i,
  output logic [15:0]          reg_rdata_o,
  input  logic [1:0]           core_mask_i,
  input  logic                 irq_ack_i,
  output logic                 irq_req_o,
  output logic [1:0]           irq_lvl_o,
  output logic [6:0]           irq_vec_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0][1:0] prio;
  logic [VEC_W-1:0]        fast0, fast1;
  logic                    edge_sel, ext_req, ext_ack;
  logic [NUM_SRC-1:0]      raw, pend, excl;

  logic                    win_valid;
  logic [IDX_W-1:0]        win_idx;
  logic [LVL_W-1:0]        win_lvl;
  logic [VEC_W-1:0]        win_vec;

  logic                    req_q, req_d;
  logic [IDX_W-1:0]        idx_q, idx_d;
  logic [LVL_W-1:0]        lvl_q, lvl_d;
  logic [VEC_W-1:0]        vec_q, vec_d;
  logic                    still_ok, keep;

  prio_irq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .pend_i(pend), .sending_i(req_q),
    .prio_o(prio), .fast0_o(fast0), .fast1_o(fast1), .edge_sel_o(edge_sel)
  );

  assign ext_ack = irq_ack_i && req_q && (idx_q == '0);

  prio_irq_ext_pin u_pin (
    .clk_i, .rst_ni, .pin_ni(ext_irq_ni), .edge_sel_i(edge_sel),
    .lowpwr_i, .ack_i(ext_ack), .req_o(ext_req)
  );

  assign raw = {src_req_i, ext_req};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    assign pend[i] = raw[i] && (prio[i] != PRIO_OFF);
    assign excl[i] = irq_ack_i && req_q && (idx_q == IDX_W'(i));
  end

  prio_irq_arbiter #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE)) u_arb (
    .pend_i(pend), .excl_i(excl), .prio_i(prio), .fast0_i(fast0), .fast1_i(fast1),
    .mask_i(core_mask_i), .win_valid_o(win_valid), .win_idx_o(win_idx),
    .win_lvl_o(win_lvl), .win_vec_o(win_vec)
  );

  assign still_ok = pend[idx_q] && (code_to_lvl(prio[idx_q]) >= core_mask_i);
  assign keep     = req_q && !irq_ack_i && still_ok;

  // next state of the presented request
  always_comb begin
    req_d = req_q;
    idx_d = idx_q;
    lvl_d = lvl_q;
    vec_d = vec_q;
    if (!keep) begin
      req_d = win_valid;
      idx_d = win_idx;
      lvl_d = win_lvl;
      vec_d = win_vec;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      req_q <= req_d;
      idx_q <= idx_d;
      lvl_q <= lvl_d;
      vec_q <= vec_d;
    end
  end

  assign irq_req_o = req_q;
  assign irq_lvl_o = lvl_q;
  assign irq_vec_o = vec_q;

  // R2
  lvl_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_lvl_o != 2'd3));

  // R6
  lvl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_lvl_o >= $past(core_mask_i)));

  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && !irq_ack_i && still_ok) |=> (irq_req_o && $stable(irq_vec_o) && $stable(irq_lvl_o)));

  // R7
  excl_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(excl));

  // R4
  win_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |-> (pend[win_idx] && !excl[win_idx]));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS-2:0] src_req = '0;
  logic        ext_n = 1'b1;
  logic        lowpwr = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  mask = '0;
  logic        ack = 1'b0;
  logic        irq_req;
  logic [1:0]  irq_lvl;
  logic [6:0]  irq_vec;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [15:0] shadow [2];

  always #10 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(src_req), .ext_irq_ni(ext_n),
    .lowpwr_i(lowpwr), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .core_mask_i(mask),
    .irq_ack_i(ack), .irq_req_o(irq_req), .irq_lvl_o(irq_lvl), .irq_vec_o(irq_vec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    reg_addr = 5'(a);
    #1 d = reg_rdata;
  endtask

  task automatic set_prio(input int s, input logic [1:0] code);
    shadow[s/8][2*(s%8) +: 2] = code;
    wr(4 + s/8, shadow[s/8]);
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic r, input logic [1:0] l, input logic [6:0] v);
    check(req, {31'b0, irq_req}, {31'b0, r});
    if (r) begin
      check(req, {30'b0, irq_lvl}, {30'b0, l});
      check(req, {25'b0, irq_vec}, {25'b0, v});
    end
  endtask

  task automatic clean;
    src_req = '0; ext_n = 1'b1; lowpwr = 1'b0; mask = '0;
    cyc(5);
    shadow[0] = '0; shadow[1] = '0;
    wr(4, 16'h0); wr(5, 16'h0); wr(1, 16'h0); wr(2, 16'h0); wr(0, 16'h0);
    cyc(2);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    expect_out("R1 req", 1'b0, 2'd0, 7'd0);
    rd(0, d); check("R1 ctl", {16'b0, d}, 32'h0);
    rd(1, d); check("R1 fast0", {16'b0, d}, 32'h0);
    rd(2, d); check("R1 fast1", {16'b0, d}, 32'h0);
    rd(4, d); check("R1 prio4", {16'b0, d}, 32'h0);
    rd(5, d); check("R1 prio5", {16'b0, d}, 32'h0);
  endtask

  task automatic t_disable_pend;
    logic [15:0] d;
    src_req[4] = 1'b1;            // source 5, vector 7
    cyc(2);
    expect_out("R2 disabled", 1'b0, 2'd0, 7'd0);
    rd(6, d); check("R3 pend off", {16'b0, d}, 32'h0);
    set_prio(5, 2'b10);
    cyc(2);
    expect_out("R2 code10", 1'b1, 2'd1, 7'd7);
    rd(6, d); check("R3 pend bit5", {16'b0, d}, 32'h0020);
    wr(6, 16'hFFFF);
    rd(6, d); check("R3 write ignored", {16'b0, d}, 32'h0020);
    rd(0, d); check("R8 status set", {16'b0, d}, 32'h8000);
    wr(0, 16'h8000);
    rd(0, d); check("R8 status ro", {16'b0, d}, 32'h8000);
    clean();
    rd(0, d); check("R8 status clear", {16'b0, d}, 32'h0);
  endtask

  task automatic t_levels;
    set_prio(3, 2'b11); set_prio(5, 2'b10);
    @(negedge clk); src_req[2] = 1'b1; src_req[4] = 1'b1;
    @(negedge clk);
    expect_out("R12 R4 level", 1'b1, 2'd2, 7'd5);
    clean();
    set_prio(6, 2'b10); set_prio(9, 2'b10);
    @(negedge clk); src_req[5] = 1'b1; src_req[8] = 1'b1;
    cyc(2);
    expect_out("R4 tie lowest", 1'b1, 2'd1, 7'd8);
    clean();
    set_prio(7, 2'b01);
    @(negedge clk); src_req[6] = 1'b1;
    cyc(2);
    expect_out("R2 code01", 1'b1, 2'd0, 7'd9);
    clean();
  endtask

  task automatic t_fast;
    set_prio(6, 2'b10); set_prio(9, 2'b10);
    wr(1, 16'd11); wr(2, 16'd8);
    @(negedge clk); src_req[5] = 1'b1; src_req[8] = 1'b1;
    cyc(2);
    expect_out("R5 fast0 over fast1", 1'b1, 2'd1, 7'd11);
    clean();
    set_prio(6, 2'b10); set_prio(9, 2'b10);
    wr(2, 16'd11);
    @(negedge clk); src_req[5] = 1'b1; src_req[8] = 1'b1;
    cyc(2);
    expect_out("R5 fast1 over lower vec", 1'b1, 2'd1, 7'd11);
    clean();
    set_prio(3, 2'b11); set_prio(9, 2'b10);
    wr(1, 16'd11);
    @(negedge clk); src_req[2] = 1'b1; src_req[8] = 1'b1;
    cyc(2);
    expect_out("R5 higher level beats fast", 1'b1, 2'd2, 7'd5);
    clean();
  endtask

  task automatic t_mask;
    set_prio(5, 2'b10);
    mask = 2'd2;
    @(negedge clk); src_req[4] = 1'b1;
    cyc(3);
    expect_out("R6 masked", 1'b0, 2'd0, 7'd0);
    mask = 2'd1;
    cyc(2);
    expect_out("R6 equal mask", 1'b1, 2'd1, 7'd7);
    mask = 2'd2;
    cyc(1);
    expect_out("R6 mask raised", 1'b0, 2'd0, 7'd0);
    clean();
  endtask

  task automatic t_hold;
    set_prio(5, 2'b01); set_prio(3, 2'b11);
    @(negedge clk); src_req[4] = 1'b1;
    cyc(2);
    expect_out("R7 first", 1'b1, 2'd0, 7'd7);
    src_req[2] = 1'b1;
    cyc(3);
    expect_out("R7 held", 1'b1, 2'd0, 7'd7);
    pulse_ack();
    expect_out("R7 after ack", 1'b1, 2'd2, 7'd5);
    src_req[2] = 1'b0;
    cyc(2);
    expect_out("R7 withdrawn", 1'b1, 2'd0, 7'd7);
    clean();
  endtask

  task automatic t_ext;
    logic [15:0] d;
    set_prio(0, 2'b11);
    @(negedge clk); ext_n = 1'b0;
    cyc(4);
    expect_out("R9 level low", 1'b1, 2'd2, 7'd2);
    ext_n = 1'b1;
    cyc(4);
    expect_out("R9 level released", 1'b0, 2'd0, 7'd0);
    wr(0, 16'h0001);
    @(negedge clk); ext_n = 1'b0;
    cyc(3); ext_n = 1'b1;
    cyc(5);
    expect_out("R10 edge latched", 1'b1, 2'd2, 7'd2);
    pulse_ack();
    cyc(1);
    expect_out("R10 cleared by ack", 1'b0, 2'd0, 7'd0);
    rd(6, d); check("R10 pend clear", {16'b0, d}, 32'h0);
    lowpwr = 1'b1;
    @(negedge clk); ext_n = 1'b0;
    cyc(3); ext_n = 1'b1;
    cyc(5);
    expect_out("R11 no edge in lowpwr", 1'b0, 2'd0, 7'd0);
    ext_n = 1'b0;
    cyc(4);
    expect_out("R11 level in lowpwr", 1'b1, 2'd2, 7'd2);
    rd(0, d); check("R11 bit kept", {16'b0, d}, 32'h8001);
    clean();
  endtask

  initial begin
    shadow[0] = '0; shadow[1] = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_disable_pend();
    t_levels();
    t_fast();
    t_mask();
    t_hold();
    t_ext();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule